// File: doc/BRIEF.md
# Bulk Command Register Writer

This block sits behind a byte-wide command stream and turns the register-write commands found in it into updates of a 256-entry register file. Each command opens with a fixed lead byte and a command code. The block acts on register writes and discards everything else. A copy command is stepped over by its known payload length. Bytes that arrive while the block is looking for a lead byte are dropped until a lead byte appears.

Every register has two copies, a shadow entry and an active entry. The display timing logic sees the active file as one flat bus, and it also sees decoded views of the colour-depth register and the two frame base addresses. A write of 0x00 to register 0xFF locks the register file. While it is locked, writes reach only the shadow file. A write of 0xFF to register 0xFF unlocks it and copies the whole shadow file into the active file in one clock. A whole block of timing values can therefore be staged and then take effect together.

Top module: `bulk_reg_writer`

## Requirements
- R1: After reset every active register reads zero, the file is unlocked, err_o is low and ready_o is high.
- R2: While the parser is looking for a lead byte, any byte other than 0xAF is dropped and has no effect on the register outputs.
- R3: The sequence 0xAF, 0x20, address, value writes the value into the register at that address. While unlocked, the new value shows on regs_o (entry n at bits n*8+7..n*8) in the cycle after the value byte is accepted.
- R4: A write of 0x00 to address 0xFF locks the file. While locked, writes change only the shadow copy and regs_o holds its value. A write of any other value than 0x00 or 0xFF to 0xFF is stored like an ordinary register and leaves the lock state unchanged.
- R5: A write of 0xFF to address 0xFF clears the lock. In the same clock it copies every shadow entry, including that write itself, into the active file.
- R6: The sequence 0xAF, 0x6A is followed by exactly 7 payload bytes. These are consumed whatever their values and change no register. The byte after them is treated as a lead byte.
- R7: A command code other than 0x20 or 0x6A, including 0xAF, raises err_o for exactly one cycle, in the cycle after the code byte is accepted. The parser then looks for a lead byte again.
- R8: A byte is accepted only in a cycle where valid_i is high. Cycles with valid_i low, including cycles in the middle of a command, change neither the registers nor the parser's progress.
- R9: depth_16bpp_o is high exactly when active register 0x00 is zero.
- R10: base16_o is {reg 0x20, reg 0x21, reg 0x22} and base8_o is {reg 0x26, reg 0x27, reg 0x28}. In each, the lowest register number is the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Command stream byte |
| valid_i | input | 1 | byte_i holds a byte this cycle |
| ready_o | output | 1 | Block accepts a byte (always high) |
| regs_o | output | 2048 | Active register file, entry n at bits n*8+7..n*8 |
| depth_16bpp_o | output | 1 | Active colour-depth register selects 16 bpp |
| base16_o | output | 24 | Active 16 bpp frame base address |
| base8_o | output | 24 | Active 8 bpp frame base address |
| err_o | output | 1 | One-cycle pulse on an unknown command code |

## Verification
The assertions check the rules that hold on every cycle:
- a write made while unlocked lands in the next cycle;
- a locked file holds its value until an unlock write arrives;
- an unlock write clears the lock;
- an error pulse never lasts two cycles;
- an idle input cycle changes nothing.

Some behaviour shows only in the bench's scenarios, which compare the whole bus against a model after each command:
- the shadow file is copied as a whole on unlock;
- a copy payload that holds lead and write codes is skipped;
- the parser resynchronises after junk bytes and after unknown codes.

// File: rtl/bulk_reg_writer_pkg.sv
package bulk_reg_writer_pkg;
  localparam logic [7:0] LEAD_BYTE  = 8'hAF;
  localparam logic [7:0] OP_WRREG   = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] CTRL_ADDR  = 8'hFF;
  localparam logic [7:0] VAL_LOCK   = 8'h00;
  localparam logic [7:0] VAL_UNLOCK = 8'hFF;
  localparam int         COPY_LEN   = 7;
  localparam int         REG_DEPTH  = 'h00;
  localparam int         REG_BASE16 = 'h20;
  localparam int         REG_BASE8  = 'h26;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CODE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } pstate_e;
endpackage

// File: rtl/bulk_cmd_parser.sv
module bulk_cmd_parser
  import bulk_reg_writer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              valid_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              err_o
);
  localparam int SKIP_W = $clog2(COPY_LEN + 1);

  pstate_e           state_q, state_d;
  logic [7:0]        addr_q, addr_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              err_q, err_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    skip_d  = skip_q;
    err_d   = 1'b0;
    if (valid_i) begin
      unique case (state_q)
        ST_HUNT: if (byte_i == LEAD_BYTE) state_d = ST_CODE;
        ST_CODE: begin
          if (byte_i == OP_WRREG) begin
            state_d = ST_ADDR;
          end else if (byte_i == OP_COPY) begin
            state_d = ST_SKIP;
            skip_d  = SKIP_W'(COPY_LEN);
          end else begin
            state_d = ST_HUNT;
            err_d   = 1'b1;
          end
        end
        ST_ADDR: begin
          addr_d  = byte_i;
          state_d = ST_DATA;
        end
        ST_DATA: state_d = ST_HUNT;
        ST_SKIP: begin
          skip_d = skip_q - SKIP_W'(1);
          if (skip_q == SKIP_W'(1)) state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      addr_q  <= '0;
      skip_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      skip_q  <= skip_d;
      err_q   <= err_d;
    end
  end

  assign wr_en_o   = valid_i && (state_q == ST_DATA);
  assign wr_addr_o = addr_q[ADDR_W-1:0];
  assign wr_data_o = byte_i[DATA_W-1:0];
  assign err_o     = err_q;
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import bulk_reg_writer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    regs_o,
  output logic                             locked_o
);
  localparam int N_REGS = 1 << ADDR_W;

  logic ctrl_hit, lock_cmd, unlock_cmd, locked_q;

  assign ctrl_hit   = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));
  assign lock_cmd   = ctrl_hit && (wr_data_i == DATA_W'(VAL_LOCK));
  assign unlock_cmd = ctrl_hit && (wr_data_i == DATA_W'(VAL_UNLOCK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         locked_q <= 1'b0;
    else if (unlock_cmd) locked_q <= 1'b0;
    else if (lock_cmd)   locked_q <= 1'b1;
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] shadow_q, shadow_d, active_q;

    assign hit      = wr_en_i && (wr_addr_i == ADDR_W'(i));
    assign shadow_d = hit ? wr_data_i : shadow_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        shadow_q <= shadow_d;
        if (unlock_cmd)          active_q <= shadow_d;
        else if (hit && !locked_q) active_q <= wr_data_i;
      end
    end

    assign regs_o[i*DATA_W +: DATA_W] = active_q;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/bulk_reg_writer.sv
module bulk_reg_writer
  import bulk_reg_writer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [7:0]                    byte_i,
  input  logic                          valid_i,
  output logic                          ready_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  output logic                          depth_16bpp_o,
  output logic [3*DATA_W-1:0]           base16_o,
  output logic [3*DATA_W-1:0]           base8_o,
  output logic                          err_o
);
  logic              wr_en, locked;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  bulk_cmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_i    (byte_i),
    .valid_i   (valid_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .err_o     (err_o)
  );

  shadow_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs_o),
    .locked_o  (locked)
  );

  assign ready_o       = 1'b1;
  assign depth_16bpp_o = (regs_o[REG_DEPTH*DATA_W +: DATA_W] == '0);
  assign base16_o      = {regs_o[REG_BASE16*DATA_W +: DATA_W],
                          regs_o[(REG_BASE16+1)*DATA_W +: DATA_W],
                          regs_o[(REG_BASE16+2)*DATA_W +: DATA_W]};
  assign base8_o       = {regs_o[REG_BASE8*DATA_W +: DATA_W],
                          regs_o[(REG_BASE8+1)*DATA_W +: DATA_W],
                          regs_o[(REG_BASE8+2)*DATA_W +: DATA_W]};
endmodule

// File: rtl/bulk_reg_writer_chk.sv
module bulk_reg_writer_chk
  import bulk_reg_writer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          valid_i,
  input logic                          err_o,
  input logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  input logic                          locked_i,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i
);
  logic unlock_wr;
  assign unlock_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR)) &&
                     (wr_data_i == DATA_W'(VAL_UNLOCK));

  // R3
  a_r3_unlocked_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_i && wr_en_i) |=>
      regs_o[int'($past(wr_addr_i))*DATA_W +: DATA_W] == $past(wr_data_i));

  // R4
  a_r4_locked_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && !unlock_wr) |=> $stable(regs_o));

  // R5
  a_r5_unlock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_wr |=> !locked_i);

  // R7
  a_r7_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R8
  a_r8_idle_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(regs_o) && !err_o));
endmodule

bind bulk_reg_writer bulk_reg_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .err_o     (err_o),
  .regs_o    (regs_o),
  .locked_i  (locked),
  .wr_en_i   (wr_en),
  .wr_addr_i (wr_addr),
  .wr_data_i (wr_data)
);

// File: tb/bulk_reg_writer_bench.sv
module bulk_reg_writer_bench;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    byte_i = 8'h00;
  logic          valid_i = 1'b0;
  logic          ready_o, depth_16bpp_o, err_o;
  logic [2047:0] regs_o;
  logic [23:0]   base16_o, base8_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_shadow [256];
  logic [7:0] m_active [256];
  bit         m_locked;

  always #4 clk_i = ~clk_i;

  bulk_reg_writer u_bulk_reg_writer (
    .clk_i, .rst_ni, .byte_i, .valid_i, .ready_o, .regs_o,
    .depth_16bpp_o, .base16_o, .base8_o, .err_o
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the next negedge
  task automatic put(logic [7:0] b);
    byte_i  = b;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    byte_i  = 8'h00;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  function automatic void model_write(logic [7:0] a, logic [7:0] d);
    m_shadow[a] = d;
    if (a == 8'hFF && d == 8'hFF) begin
      for (int k = 0; k < 256; k++) m_active[k] = m_shadow[k];
      m_locked = 1'b0;
    end else begin
      if (!m_locked) m_active[a] = d;
      if (a == 8'hFF && d == 8'h00) m_locked = 1'b1;
    end
  endfunction

  function automatic logic [23:0] exp_base(int hi);
    return {m_active[hi], m_active[hi+1], m_active[hi+2]};
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d, bit stall);
    put(8'hAF);
    if (stall) idle(2);
    put(8'h20);
    if (stall) idle(1);
    put(a);
    if (stall) idle(3);
    put(d);
    model_write(a, d);
  endtask

  task automatic check_regs(string req);
    int bad = -1;
    for (int k = 0; k < 256; k++)
      if (bad < 0 && regs_o[k*8 +: 8] !== m_active[k]) bad = k;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {bad[7:0], 16'h0, regs_o[bad*8 +: 8]}, {bad[7:0], 16'h0, m_active[bad]});
  endtask

  task automatic check_views(string req);
    chk(depth_16bpp_o === (m_active[0] == 8'h00), {req, " R9 depth"},
        32'(depth_16bpp_o), 32'(m_active[0] == 8'h00));
    chk(base16_o === exp_base('h20), {req, " R10 base16"}, 32'(base16_o), 32'(exp_base('h20)));
    chk(base8_o === exp_base('h26), {req, " R10 base8"}, 32'(base8_o), 32'(exp_base('h26)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] addrs [8];
    void'($urandom(32'h5EED_1234));
    addrs = '{8'h00, 8'h20, 8'h21, 8'h22, 8'h26, 8'h27, 8'h28, 8'h42};
    for (int k = 0; k < 256; k++) begin m_shadow[k] = 0; m_active[k] = 0; end
    m_locked = 1'b0;

    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    check_regs("R1 reset regs");
    chk(err_o === 1'b0, "R1 err low", 32'(err_o), 0);
    chk(ready_o === 1'b1, "R1 ready high", 32'(ready_o), 1);
    check_views("R1");

    // R3 unlocked writes, R10 base16 order
    wr(8'h20, 8'h12, 0); wr(8'h21, 8'h34, 0); wr(8'h22, 8'h56, 0);
    check_regs("R3 unlocked write");
    chk(base16_o === 24'h123456, "R10 base16 order", 32'(base16_o), 32'h123456);
    wr(8'h00, 8'h01, 0);
    chk(depth_16bpp_o === 1'b0, "R9 depth nonzero", 32'(depth_16bpp_o), 0);

    // R4 lock, staged writes invisible
    wr(8'hFF, 8'h00, 0);
    wr(8'h26, 8'hAB, 0); wr(8'h27, 8'hCD, 1); wr(8'h28, 8'hEF, 0); wr(8'h00, 8'h00, 0);
    check_regs("R4 locked holds");
    chk(base8_o === 24'h0, "R4 base8 held", 32'(base8_o), 0);
    wr(8'hFF, 8'h5A, 0);
    wr(8'h30, 8'h77, 0);
    check_regs("R4 other ctrl value keeps lock");
    // R5 unlock copies shadow
    wr(8'hFF, 8'hFF, 0);
    check_regs("R5 unlock copy");
    chk(base8_o === 24'hABCDEF, "R5 R10 base8 after unlock", 32'(base8_o), 32'hABCDEF);
    chk(depth_16bpp_o === 1'b1, "R5 R9 depth back to 16", 32'(depth_16bpp_o), 1);

    // R6 copy payload holding command-like bytes
    put(8'hAF); put(8'h6A);
    put(8'hAF); put(8'h20); put(8'h21); put(8'h99); put(8'hAF); put(8'h20); put(8'h05);
    check_regs("R6 copy skipped");
    wr(8'h43, 8'h3C, 0);
    check_regs("R6 resync after copy");

    // R2 junk bytes
    put(8'h20); put(8'h43); put(8'h00); put(8'h11);
    check_regs("R2 junk dropped");
    wr(8'h44, 8'h4D, 0);
    check_regs("R2 write after junk");

    // R7 unknown code
    put(8'hAF); put(8'h55);
    chk(err_o === 1'b1, "R7 err pulse", 32'(err_o), 1);
    idle(1);
    chk(err_o === 1'b0, "R7 err one cycle", 32'(err_o), 0);
    put(8'h20); put(8'h05); put(8'h77);
    check_regs("R7 back to hunt");
    put(8'hAF); put(8'hAF);
    chk(err_o === 1'b1, "R7 lead as code is error", 32'(err_o), 1);
    put(8'h20);
    chk(err_o === 1'b0, "R7 err drops", 32'(err_o), 0);
    check_regs("R7 no write after lead-as-code");

    // R8 stalled command
    wr(8'h45, 8'hC3, 1);
    check_regs("R8 stalled write");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind = $urandom % 8;
      if (kind <= 3 || kind == 7) begin
        logic [7:0] a, d;
        int pick = $urandom % 10;
        if (pick == 0) begin a = 8'hFF; d = ($urandom % 2) ? 8'hFF : 8'h00; end
        else begin a = (pick < 6) ? addrs[$urandom % 8] : 8'($urandom); d = 8'($urandom); end
        wr(a, d, kind == 7);
      end else if (kind == 4) begin
        put(8'hAF); put(8'h6A);
        for (int p = 0; p < 7; p++) put(8'($urandom));
      end else if (kind == 5) begin
        int n = 1 + $urandom % 3;
        for (int p = 0; p < n; p++) begin
          logic [7:0] j = 8'($urandom);
          if (j == 8'hAF) j = 8'h20;
          put(j);
        end
      end else begin
        idle(1 + $urandom % 3);
      end
      check_regs("R3 R4 R5 random");
      check_views("random");
    end
    wr(8'hFF, 8'hFF, 0);
    check_regs("R5 final unlock");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule